// File: doc/BRIEF.md
# Coil Driver Power Mode Controller

This block decides when the coil output stage of a lens-focus actuator driver may run. It holds a three-state machine, SHUTDOWN, STANDBY and ACTIVE, and drives the output-stage enable together with single-cycle strobes. These strobes tell the surrounding register file to load its defaults, clear the current setpoint, clear the status flags, or set individual status flags. Its inputs are the serial clock line level (already synchronized to the system clock), the 10-bit coil current setpoint held in the register file, a soft-reset request, and five fault condition levels from the analog sensing.

A long low level on the serial clock line powers the block down. Holding that line low for `IDLE_CYCLES` system clocks is treated as a request to shut down, and the next rising edge on the line wakes the block into STANDBY. A non-zero setpoint moves it from STANDBY into ACTIVE. A setpoint of zero, a soft reset or a serious fault sends it back to STANDBY. After a thermal trip, ACTIVE cannot be entered again until the thermal condition has gone away.

The states and transitions are as follows. **Wake** goes from SHUTDOWN to STANDBY. **Engage** goes from STANDBY to ACTIVE. **Release** goes from ACTIVE to STANDBY on a zero setpoint. **Soft reset** goes from ACTIVE to STANDBY, or from STANDBY to STANDBY. **Trip** goes from ACTIVE to STANDBY on a fault. **Idle-off** goes from STANDBY or ACTIVE to SHUTDOWN.

Top module: `vcm_power_ctl`

## Requirements
- R1: While `rst_n` is low and on its release, `mode` reads SHUTDOWN and every other output is low. The `mode` encoding is SHUTDOWN=0, STANDBY=1, ACTIVE=2.
- R2: If `scl_level` is sampled low on `IDLE_CYCLES` consecutive clock edges, `mode` becomes SHUTDOWN on the following edge, whatever the state was. A run of `IDLE_CYCLES-1` low samples has no effect. The block stays in SHUTDOWN while the line stays low.
- R3: In SHUTDOWN, a low-to-high change of `scl_level` moves `mode` to STANDBY and pulses `defaults_load` for exactly that cycle. A line that is already high when reset is released counts as such a change.
- R4: STANDBY moves to ACTIVE when `setpoint` is non-zero. ACTIVE returns to STANDBY when `setpoint` becomes zero.
- R5: A `soft_reset` request in ACTIVE or in STANDBY leaves the block in STANDBY and pulses `defaults_load` for one cycle.
- R6: In ACTIVE, a thermal fault, a qualified short or a qualified open moves the block to STANDBY. The same cycle pulses `setpoint_clr` and raises the matching bits of `flag_set`. The bit positions are: over-current bit 0, undervoltage bit 1, open bit 2, short bit 3, thermal bit 4.
- R7: Short and open faults count only while `setpoint` is at least `DET_MIN` (256). Below that value they leave the block in ACTIVE and set no flag bit.
- R8: After a thermal trip, and in any cycle where `flt_thermal` is high, STANDBY does not move to ACTIVE. Entry becomes possible again one cycle after `flt_thermal` falls.
- R9: `drv_en` is high exactly while `mode` is ACTIVE.
- R10: When exit conditions coincide, the winner is chosen in this order: idle-off, then soft reset, then fault, then zero setpoint. A losing condition produces none of its own strobes.
- R11: In ACTIVE, over-current and undervoltage raise their `flag_set` bits in each cycle that they are present, and the block stays in ACTIVE.
- R12: `status_clr` pulses for one cycle on each STANDBY-to-ACTIVE transition and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_level | input | 1 | Serial clock line level, already synchronized |
| setpoint | input | 10 | Coil current code from the register file |
| soft_reset | input | 1 | Software reset request |
| flt_thermal | input | 1 | Over-temperature condition |
| flt_short | input | 1 | Coil short condition |
| flt_open | input | 1 | Coil open condition |
| flt_overcur | input | 1 | Over-current condition |
| flt_undervolt | input | 1 | Supply undervoltage condition |
| mode | output | 2 | Current state: 0 SHUTDOWN, 1 STANDBY, 2 ACTIVE |
| drv_en | output | 1 | Output-stage enable |
| defaults_load | output | 1 | Strobe: load register defaults |
| setpoint_clr | output | 1 | Strobe: clear the setpoint register |
| status_clr | output | 1 | Strobe: clear all status flags |
| flag_set | output | 5 | Strobes that set individual status flags |

## Verification
The assertions assume that `scl_level` and the fault levels are already synchronous to `clk`. They also assume that `setpoint` and `soft_reset` change only between clock edges, and that the register file acts on `setpoint_clr` and `defaults_load` by lowering `setpoint`. The stimulus is driven on falling clock edges only. After every clear strobe the bench itself writes the setpoint back to zero or to a new code, which models the register file, so no input violates these assumptions. The idle window is shortened through the parameter so that runs of exactly `IDLE_CYCLES-1` and `IDLE_CYCLES` low samples can both be exercised.

// File: rtl/vcm_pwr_pkg.sv
package vcm_pwr_pkg;

    typedef enum logic [1:0] {
        PM_SHUTDOWN = 2'd0,
        PM_STANDBY  = 2'd1,
        PM_ACTIVE   = 2'd2
    } pwr_mode_t;

    localparam int FLAG_N     = 5;
    localparam int FLG_OVC    = 0;
    localparam int FLG_UVL    = 1;
    localparam int FLG_OPEN   = 2;
    localparam int FLG_SHORT  = 3;
    localparam int FLG_THERM  = 4;

endpackage

// File: rtl/vcm_scl_idle.sv
// Counts consecutive low samples of the serial clock line and detects its
// rising edge. The count saturates at the limit and restarts on any high.
module vcm_scl_idle #(
    parameter int IDLE_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_level,
    output logic idle_expired,
    output logic scl_rise
);
    localparam int CW = $clog2(IDLE_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYCLES);

    logic [CW-1:0] low_cnt_q;
    logic          scl_d_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
            scl_d_q   <= 1'b0;
        end else begin
            scl_d_q <= scl_level;
            if (scl_level) begin
                low_cnt_q <= '0;
            end else if (low_cnt_q != LIMIT) begin
                low_cnt_q <= low_cnt_q + 1'b1;
            end
        end
    end

    assign idle_expired = (low_cnt_q == LIMIT);
    assign scl_rise     = scl_level & ~scl_d_q;

endmodule

// File: rtl/vcm_fault_qual.sv
// Qualifies the coil fault conditions against the setpoint and forms the
// per-flag set vector plus the trip request for the state machine.
module vcm_fault_qual
    import vcm_pwr_pkg::*;
#(
    parameter int SP_W    = 10,
    parameter int DET_MIN = 256
) (
    input  logic [SP_W-1:0]   setpoint,
    input  logic              flt_thermal,
    input  logic              flt_short,
    input  logic              flt_open,
    input  logic              flt_overcur,
    input  logic              flt_undervolt,
    output logic              trip,
    output logic              thermal_hit,
    output logic [FLAG_N-1:0] flags
);
    localparam logic [SP_W-1:0] DET_CODE = SP_W'(DET_MIN);

    logic det_ok;
    logic short_q;
    logic open_q;

    assign det_ok  = (setpoint >= DET_CODE);
    assign short_q = flt_short & det_ok;
    assign open_q  = flt_open & det_ok;

    always_comb begin
        flags            = '0;
        flags[FLG_OVC]   = flt_overcur;
        flags[FLG_UVL]   = flt_undervolt;
        flags[FLG_OPEN]  = open_q;
        flags[FLG_SHORT] = short_q;
        flags[FLG_THERM] = flt_thermal;
    end

    assign thermal_hit = flt_thermal;
    assign trip        = flt_thermal | short_q | open_q;

endmodule

// File: rtl/vcm_pwr_fsm.sv
// Three-state power mode machine. One process holds the state register,
// one registers the strobes and the enable alongside it.
module vcm_pwr_fsm
    import vcm_pwr_pkg::*;
#(
    parameter int SP_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle_expired,
    input  logic              scl_rise,
    input  logic              sp_nonzero,
    input  logic              soft_reset,
    input  logic              trip,
    input  logic              thermal_hit,
    input  logic [FLAG_N-1:0] flags,
    output pwr_mode_t         mode_q,
    output logic              drv_en_q,
    output logic              ld_q,
    output logic              spclr_q,
    output logic              stclr_q,
    output logic [FLAG_N-1:0] flg_q
);
    pwr_mode_t         mode_d;
    logic              ld_d;
    logic              spclr_d;
    logic              stclr_d;
    logic [FLAG_N-1:0] flg_d;
    logic              lock_set;
    logic              therm_lock_q;
    logic              engage_block;

    assign engage_block = therm_lock_q | thermal_hit;

    always_comb begin
        mode_d   = mode_q;
        ld_d     = 1'b0;
        spclr_d  = 1'b0;
        stclr_d  = 1'b0;
        flg_d    = '0;
        lock_set = 1'b0;
        unique case (mode_q)
            PM_SHUTDOWN: begin
                if (scl_rise) begin
                    mode_d = PM_STANDBY;
                    ld_d   = 1'b1;
                end
            end
            PM_STANDBY: begin
                if (idle_expired) begin
                    mode_d = PM_SHUTDOWN;
                end else if (soft_reset) begin
                    ld_d = 1'b1;
                end else if (sp_nonzero && !engage_block) begin
                    mode_d  = PM_ACTIVE;
                    stclr_d = 1'b1;
                end
            end
            PM_ACTIVE: begin
                if (idle_expired) begin
                    mode_d = PM_SHUTDOWN;
                end else if (soft_reset) begin
                    mode_d = PM_STANDBY;
                    ld_d   = 1'b1;
                end else if (trip) begin
                    mode_d   = PM_STANDBY;
                    spclr_d  = 1'b1;
                    flg_d    = flags;
                    lock_set = thermal_hit;
                end else if (!sp_nonzero) begin
                    mode_d = PM_STANDBY;
                end else begin
                    flg_d = flags;
                end
            end
            default: begin
                mode_d = PM_SHUTDOWN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= PM_SHUTDOWN;
        end else begin
            mode_q <= mode_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_en_q     <= 1'b0;
            ld_q         <= 1'b0;
            spclr_q      <= 1'b0;
            stclr_q      <= 1'b0;
            flg_q        <= '0;
            therm_lock_q <= 1'b0;
        end else begin
            drv_en_q <= (mode_d == PM_ACTIVE);
            ld_q     <= ld_d;
            spclr_q  <= spclr_d;
            stclr_q  <= stclr_d;
            flg_q    <= flg_d;
            if (lock_set) begin
                therm_lock_q <= 1'b1;
            end else if (!thermal_hit) begin
                therm_lock_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/vcm_power_ctl.sv
module vcm_power_ctl
    import vcm_pwr_pkg::*;
#(
    parameter int IDLE_CYCLES = 50000,
    parameter int SP_W        = 10,
    parameter int DET_MIN     = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_level,
    input  logic [SP_W-1:0]   setpoint,
    input  logic              soft_reset,
    input  logic              flt_thermal,
    input  logic              flt_short,
    input  logic              flt_open,
    input  logic              flt_overcur,
    input  logic              flt_undervolt,
    output logic [1:0]        mode,
    output logic              drv_en,
    output logic              defaults_load,
    output logic              setpoint_clr,
    output logic              status_clr,
    output logic [FLAG_N-1:0] flag_set
);
    logic              idle_expired;
    logic              scl_rise;
    logic              trip;
    logic              thermal_hit;
    logic [FLAG_N-1:0] flags;
    pwr_mode_t         mode_q;

    vcm_scl_idle #(
        .IDLE_CYCLES (IDLE_CYCLES)
    ) u_idle (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_level    (scl_level),
        .idle_expired (idle_expired),
        .scl_rise     (scl_rise)
    );

    vcm_fault_qual #(
        .SP_W    (SP_W),
        .DET_MIN (DET_MIN)
    ) u_qual (
        .setpoint      (setpoint),
        .flt_thermal   (flt_thermal),
        .flt_short     (flt_short),
        .flt_open      (flt_open),
        .flt_overcur   (flt_overcur),
        .flt_undervolt (flt_undervolt),
        .trip          (trip),
        .thermal_hit   (thermal_hit),
        .flags         (flags)
    );

    vcm_pwr_fsm #(
        .SP_W (SP_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .idle_expired (idle_expired),
        .scl_rise     (scl_rise),
        .sp_nonzero   (|setpoint),
        .soft_reset   (soft_reset),
        .trip         (trip),
        .thermal_hit  (thermal_hit),
        .flags        (flags),
        .mode_q       (mode_q),
        .drv_en_q     (drv_en),
        .ld_q         (defaults_load),
        .spclr_q      (setpoint_clr),
        .stclr_q      (status_clr),
        .flg_q        (flag_set)
    );

    assign mode = mode_q;

endmodule

// File: rtl/vcm_power_ctl_chk.sv
module vcm_power_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_level,
    input logic       flt_thermal,
    input logic [1:0] mode,
    input logic       drv_en,
    input logic       defaults_load,
    input logic       setpoint_clr,
    input logic       status_clr
);
    localparam logic [1:0] M_SD = 2'd0;
    localparam logic [1:0] M_SB = 2'd1;
    localparam logic [1:0] M_AC = 2'd2;

    p_drv_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> (mode == M_AC));

    p_hold_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_SD && !scl_level) |=> (mode == M_SD));

    p_wake_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_SB && $past(mode) == M_SD) |-> defaults_load);

    p_stclr_entry_r12: assert property (@(posedge clk) disable iff (!rst_n)
        status_clr |-> (mode == M_AC && $past(mode) == M_SB));

    p_spclr_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        setpoint_clr |-> (mode == M_SB && $past(mode) == M_AC));

    p_thermal_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_SB && flt_thermal) |=> (mode != M_AC));

endmodule

bind vcm_power_ctl vcm_power_ctl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_level     (scl_level),
    .flt_thermal   (flt_thermal),
    .mode          (mode),
    .drv_en        (drv_en),
    .defaults_load (defaults_load),
    .setpoint_clr  (setpoint_clr),
    .status_clr    (status_clr)
);

// File: tb/vcm_power_ctl_tb_top.sv
module vcm_power_ctl_tb_top;
    localparam int IDLE = 12;
    localparam logic [1:0] SD = 2'd0;
    localparam logic [1:0] SB = 2'd1;
    localparam logic [1:0] AC = 2'd2;

    typedef struct {
        logic [1:0] md;
        logic       en;
        logic       dl;
        logic       spc;
        logic       stc;
        logic [4:0] fl;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic [9:0] sp = '0;
    logic       srst = 1'b0;
    logic       th = 1'b0, sh = 1'b0, op = 1'b0, oc = 1'b0, uv = 1'b0;
    logic [1:0] mode;
    logic       drv_en, defaults_load, setpoint_clr, status_clr;
    logic [4:0] flag_set;

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    exp_t q[$];

    always #5 clk = ~clk;

    vcm_power_ctl #(.IDLE_CYCLES(IDLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_level(scl), .setpoint(sp),
        .soft_reset(srst), .flt_thermal(th), .flt_short(sh), .flt_open(op),
        .flt_overcur(oc), .flt_undervolt(uv), .mode(mode), .drv_en(drv_en),
        .defaults_load(defaults_load), .setpoint_clr(setpoint_clr),
        .status_clr(status_clr), .flag_set(flag_set)
    );

    task automatic step(input logic [1:0] md, input logic en, input logic dl,
                        input logic spc, input logic stc, input logic [4:0] fl,
                        input string tag);
        exp_t e;
        e.md = md; e.en = en; e.dl = dl; e.spc = spc; e.stc = stc; e.fl = fl; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // monitor: compares one expected item per clock edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (mode !== e.md || drv_en !== e.en || defaults_load !== e.dl ||
                    setpoint_clr !== e.spc || status_clr !== e.stc || flag_set !== e.fl) begin
                    errors++;
                    $display("FAIL %s: got mode=%0d en=%b ld=%b spc=%b stc=%b fl=%b exp mode=%0d en=%b ld=%b spc=%b stc=%b fl=%b",
                             e.tag, mode, drv_en, defaults_load, setpoint_clr, status_clr, flag_set,
                             e.md, e.en, e.dl, e.spc, e.stc, e.fl);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (mode !== SD || drv_en !== 0 || defaults_load !== 0 || setpoint_clr !== 0 ||
            status_clr !== 0 || flag_set !== 0) begin
            errors++;
            $display("FAIL R1: got mode=%0d en=%b fl=%b exp mode=0 all low", mode, drv_en, flag_set);
        end
        rst_n = 1'b1;
        // R3: line already high at reset release counts as a wake edge
        step(SB, 0, 1, 0, 0, 5'b0, "R3 wake");
        step(SB, 0, 0, 0, 0, 5'b0, "R3 one-cycle load");
        sp = 10'd100;
        step(AC, 1, 0, 0, 1, 5'b0, "R4 engage / R12 status clear");
        step(AC, 1, 0, 0, 0, 5'b0, "R9 enable held");
        sp = 10'd0;
        step(SB, 0, 0, 0, 0, 5'b0, "R4 release");
        sp = 10'd300;
        step(AC, 1, 0, 0, 1, 5'b0, "R12 re-entry clear");
        oc = 1;
        step(AC, 1, 0, 0, 0, 5'b00001, "R11 overcurrent");
        oc = 0; uv = 1;
        step(AC, 1, 0, 0, 0, 5'b00010, "R11 undervoltage");
        uv = 0; op = 1;
        step(SB, 0, 0, 1, 0, 5'b00100, "R6 open trip");
        op = 0; sp = 10'd0;
        step(SB, 0, 0, 0, 0, 5'b0, "R6 after trip");
        sp = 10'd200;
        step(AC, 1, 0, 0, 1, 5'b0, "R4 engage low code");
        sh = 1;
        step(AC, 1, 0, 0, 0, 5'b0, "R7 short ignored below 256");
        sh = 0; op = 1; sp = 10'd255;
        step(AC, 1, 0, 0, 0, 5'b0, "R7 open ignored at 255");
        op = 0; sh = 1; sp = 10'd600;
        step(SB, 0, 0, 1, 0, 5'b01000, "R6 short trip");
        sh = 0; sp = 10'd0;
        step(SB, 0, 0, 0, 0, 5'b0, "R6 idle");
        sp = 10'd600;
        step(AC, 1, 0, 0, 1, 5'b0, "R4 engage");
        th = 1;
        step(SB, 0, 0, 1, 0, 5'b10000, "R6 thermal trip");
        for (int i = 0; i < 3; i++) step(SB, 0, 0, 0, 0, 5'b0, "R8 blocked while hot");
        th = 0;
        step(SB, 0, 0, 0, 0, 5'b0, "R8 lock one more cycle");
        step(AC, 1, 0, 0, 1, 5'b0, "R8 entry after cooling");
        srst = 1;
        step(SB, 0, 1, 0, 0, 5'b0, "R5 soft reset in active");
        srst = 0; sp = 10'd0;
        step(SB, 0, 0, 0, 0, 5'b0, "R5 settle");
        srst = 1; sp = 10'd5;
        step(SB, 0, 1, 0, 0, 5'b0, "R5 soft reset in standby");
        srst = 0;
        step(AC, 1, 0, 0, 1, 5'b0, "R4 engage after soft reset");
        srst = 1; th = 1;
        step(SB, 0, 1, 0, 0, 5'b0, "R10 soft reset beats fault");
        srst = 0; th = 0; sp = 10'd0;
        step(SB, 0, 0, 0, 0, 5'b0, "R10 settle");
        sp = 10'd7;
        step(AC, 1, 0, 0, 1, 5'b0, "R10 no lock after soft reset");
        sp = 10'd0; th = 1;
        step(SB, 0, 0, 1, 0, 5'b10000, "R10 fault beats zero setpoint");
        th = 0;
        step(SB, 0, 0, 0, 0, 5'b0, "R8 cool 1");
        step(SB, 0, 0, 0, 0, 5'b0, "R8 cool 2");
        sp = 10'd7;
        step(AC, 1, 0, 0, 1, 5'b0, "R4 engage");
        scl = 0;
        for (int i = 0; i < IDLE - 1; i++) step(AC, 1, 0, 0, 0, 5'b0, "R2 short low run");
        scl = 1;
        step(AC, 1, 0, 0, 0, 5'b0, "R2 no shutdown at N-1");
        scl = 0;
        for (int i = 0; i < IDLE; i++) step(AC, 1, 0, 0, 0, 5'b0, "R2 low run");
        srst = 1; th = 1;
        step(SD, 0, 0, 0, 0, 5'b0, "R2 R10 idle-off beats reset and fault");
        srst = 0; th = 0;
        for (int i = 0; i < 4; i++) step(SD, 0, 0, 0, 0, 5'b0, "R2 stays off");
        scl = 1;
        step(SB, 0, 1, 0, 0, 5'b0, "R3 wake from shutdown");
        step(AC, 1, 0, 0, 1, 5'b0, "R4 R12 engage");
        sp = 10'd0; scl = 0;
        step(SB, 0, 0, 0, 0, 5'b0, "R4 release");
        for (int i = 0; i < IDLE - 1; i++) step(SB, 0, 0, 0, 0, 5'b0, "R2 standby low run");
        step(SD, 0, 0, 0, 0, 5'b0, "R2 standby idle-off");
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule